// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block is a trace sink. While capture is running in circular mode, it stores each valid 32-bit trace word in an on-chip RAM that it uses as a ring. The write pointer wraps at a programmable ring length. A sticky flag records that the ring has been overwritten at least once. Capture can end in three ways: software disables it, a programmed number of words have been stored after a trigger, or a flush completes while stop-on-flush is selected.

Once capture has ended and the one-stage input pipeline has drained, the block positions its read pointer at the oldest stored word. That word is at the write pointer if the ring has wrapped, and at word 0 if it has not. Each read of the data register returns the next stored word in age order. When none are left, the data register returns all-ones. Software reaches every setting through a small register port with one-cycle registered reads. The register addresses are CTRL=0, STATUS=1, MODE=2, SIZE=3, TCOUNT=4, FLUSHCTL=5, DATA=6, RDPTR=7 and WRPTR=8.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, CTRL reads 0, STATUS reads 0x4, MODE reads 0, SIZE reads the RAM depth (16), WRPTR reads 0 and DATA reads 0xFFFFFFFF.
- R2: Writing CTRL with bit 0 set starts capture. It clears the write pointer, the wrapped flag and the triggered flag. Each accepted word is written at the write pointer, and the pointer wraps to 0 after SIZE-1. While capture is stopped and the pipeline is empty, the write pointer does not move.
- R3: MODE bits [1:0] select the behaviour. Value 0 is the circular buffer. With any other mode value, no trace word is stored.
- R4: Writes to MODE, SIZE and TCOUNT are ignored while capture runs. A SIZE write outside 1..16 is ignored.
- R5: When FLUSHCTL bit 8 is set, a trig_in pulse during capture sets STATUS bit 1. The word accepted in that cycle is stored, then exactly TCOUNT further words are stored and capture stops. If TCOUNT is 0, capture stops in the trigger cycle.
- R6: A second trigger after the first is ignored until capture is restarted. It neither reloads the count nor extends capture.
- R7: A flush starts in three ways: a write of FLUSHCTL with bit 6 set, flush_in while bit 4 is set, or an accepted trigger while bit 5 is set. FLUSHCTL bit 6 reads 1 in the cycle after the request and is cleared by hardware one cycle later.
- R8: If FLUSHCTL bit 12 is set, a completing flush stops capture (CTRL bit 0 reads 0). If bit 12 is clear, capture continues.
- R9: STATUS bit 2 (ready) is 1 only when capture is stopped, the input pipeline is empty and no flush is pending.
- R10: After capture stops, DATA reads return the stored words oldest first. There are SIZE words starting at the write pointer if the ring wrapped, otherwise WRPTR words starting at 0. Every read after that returns 0xFFFFFFFF.
- R11: RDPTR and WRPTR read back the live read and write pointers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; the data appears on reg_rdata after the next edge |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| trc_valid | input | 1 | Trace word valid |
| trc_data | input | 32 | Trace word |
| trig_in | input | 1 | Trigger input |
| flush_in | input | 1 | Flush request input |

## Verification
The hardest case to reach is a stop that lands in the same cycle as other events. Examples are a flush caused by a trigger, where the completing flush ends capture one word after the trigger, or a second trigger that arrives inside the post-trigger window. The stimulus streams a word on every cycle and pulses trig_in and flush_in at chosen offsets inside the stream. A behavioural model runs beside the design on every clock. The bench then reads back the pointers and drains the ring, so the exact number of stored words is visible at the ports.

// File: rtl/trb_pkg.sv
package trb_pkg;
   localparam int unsigned ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
   localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
   localparam logic [ADDR_W-1:0] A_MODE  = 4'd2;
   localparam logic [ADDR_W-1:0] A_SIZE  = 4'd3;
   localparam logic [ADDR_W-1:0] A_TCNT  = 4'd4;
   localparam logic [ADDR_W-1:0] A_FCTL  = 4'd5;
   localparam logic [ADDR_W-1:0] A_DATA  = 4'd6;
   localparam logic [ADDR_W-1:0] A_RPTR  = 4'd7;
   localparam logic [ADDR_W-1:0] A_WPTR  = 4'd8;

   localparam int unsigned FC_FL_IN   = 4;
   localparam int unsigned FC_FL_TRIG = 5;
   localparam int unsigned FC_FL_MAN  = 6;
   localparam int unsigned FC_TRIG_EN = 8;
   localparam int unsigned FC_STOP_FL = 12;

   localparam int unsigned ST_TRIG = 1;
   localparam int unsigned ST_RDY  = 2;

   localparam logic [1:0] MODE_CIRC = 2'd0;

   typedef struct packed {
      logic stop_fl;
      logic trig_en;
      logic fl_trig;
      logic fl_in;
   } fctl_t;
endpackage

// File: rtl/trb_ctl.sv
module trb_ctl
   import trb_pkg::*;
#(
   parameter int unsigned AW  = 4,
   parameter int unsigned TCW = 16,
   localparam int unsigned SW    = AW + 1,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   input  logic              trc_valid,
   input  logic              trig_in,
   input  logic              flush_in,
   input  logic              pipe_vld,
   output logic              active,
   output logic              accept,
   output logic              start,
   output logic              triggered,
   output logic              flush_pend,
   output fctl_t             fctl,
   output logic [1:0]        mode,
   output logic [SW-1:0]     size,
   output logic [TCW-1:0]    tcnt,
   output logic              ready
);
   logic [TCW-1:0] post_left;
   logic ctrl_wr, halt, trig_take, post_last, man_fl, flush_req, stop, size_ok;

   assign ctrl_wr   = reg_wr && (reg_addr == A_CTRL);
   assign start     = ctrl_wr && reg_wdata[0];
   assign halt      = ctrl_wr && !reg_wdata[0];
   assign accept    = active && (mode == MODE_CIRC) && trc_valid;
   assign trig_take = active && fctl.trig_en && trig_in && !triggered;
   assign post_last = accept && triggered && (post_left == TCW'(1));
   assign man_fl    = reg_wr && (reg_addr == A_FCTL) && reg_wdata[FC_FL_MAN];
   assign flush_req = man_fl || (fctl.fl_in && flush_in) || (fctl.fl_trig && trig_take);
   assign stop      = halt || (trig_take && (tcnt == '0)) || post_last
                      || (flush_pend && fctl.stop_fl);
   assign ready     = !active && !pipe_vld && !flush_pend;
   assign size_ok   = (reg_wdata != 32'd0) && (reg_wdata <= 32'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active     <= 1'b0;
         triggered  <= 1'b0;
         post_left  <= '0;
         flush_pend <= 1'b0;
         fctl       <= '0;
         mode       <= MODE_CIRC;
         size       <= SW'(DEPTH);
         tcnt       <= '0;
      end else begin
         if (start)     active <= 1'b1;
         else if (stop) active <= 1'b0;

         if (start)          triggered <= 1'b0;
         else if (trig_take) triggered <= 1'b1;

         if (trig_take)
            post_left <= tcnt;
         else if (accept && triggered && (post_left != '0))
            post_left <= post_left - TCW'(1);

         flush_pend <= flush_req;

         if (reg_wr && (reg_addr == A_FCTL)) begin
            fctl.fl_in   <= reg_wdata[FC_FL_IN];
            fctl.fl_trig <= reg_wdata[FC_FL_TRIG];
            fctl.trig_en <= reg_wdata[FC_TRIG_EN];
            fctl.stop_fl <= reg_wdata[FC_STOP_FL];
         end
         if (reg_wr && !active) begin
            if (reg_addr == A_MODE) mode <= reg_wdata[1:0];
            if (reg_addr == A_SIZE && size_ok) size <= reg_wdata[SW-1:0];
            if (reg_addr == A_TCNT) tcnt <= reg_wdata[TCW-1:0];
         end
      end
   end
endmodule

// File: rtl/trb_store.sv
module trb_store #(
   parameter int unsigned AW = 4,
   parameter int unsigned DW = 32,
   localparam int unsigned SW    = AW + 1,
   localparam int unsigned DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          start,
   input  logic [DW-1:0] din,
   input  logic [SW-1:0] size,
   input  logic [AW-1:0] rd_addr,
   output logic          pipe_vld,
   output logic [AW-1:0] wr_ptr,
   output logic          wrapped,
   output logic [DW-1:0] rd_word
);
   logic [DW-1:0] pipe_data;
   logic [DW-1:0] mem [DEPTH];
   logic          at_end;

   assign at_end  = ({1'b0, wr_ptr} == (size - SW'(1)));
   assign rd_word = mem[rd_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_vld  <= 1'b0;
         pipe_data <= '0;
         wr_ptr    <= '0;
         wrapped   <= 1'b0;
      end else begin
         pipe_vld  <= accept && !start;
         pipe_data <= din;
         if (start) begin
            wr_ptr  <= '0;
            wrapped <= 1'b0;
         end else if (pipe_vld) begin
            if (at_end) begin
               wr_ptr  <= '0;
               wrapped <= 1'b1;
            end else begin
               wr_ptr <= wr_ptr + AW'(1);
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (pipe_vld) mem[wr_ptr] <= pipe_data;
   end
endmodule

// File: rtl/trb_reader.sv
module trb_reader #(
   parameter int unsigned AW = 4,
   localparam int unsigned SW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          ready,
   input  logic          wrapped,
   input  logic [AW-1:0] wr_ptr,
   input  logic [SW-1:0] size,
   input  logic          pop,
   output logic [AW-1:0] rd_ptr,
   output logic [SW-1:0] rd_left
);
   logic ready_d, load, at_end;

   assign load   = ready && !ready_d;
   assign at_end = ({1'b0, rd_ptr} == (size - SW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_d <= 1'b1;
         rd_ptr  <= '0;
         rd_left <= '0;
      end else begin
         ready_d <= ready;
         if (start) begin
            rd_ptr  <= '0;
            rd_left <= '0;
         end else if (load) begin
            rd_ptr  <= wrapped ? wr_ptr : '0;
            rd_left <= wrapped ? size : {1'b0, wr_ptr};
         end else if (pop && (rd_left != '0)) begin
            rd_ptr  <= at_end ? '0 : rd_ptr + AW'(1);
            rd_left <= rd_left - SW'(1);
         end
      end
   end
endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf
   import trb_pkg::*;
#(
   parameter int unsigned AW  = 4,
   parameter int unsigned DW  = 32,
   parameter int unsigned TCW = 16,
   localparam int unsigned SW = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              trc_valid,
   input  logic [DW-1:0]     trc_data,
   input  logic              trig_in,
   input  logic              flush_in
);
   generate
      if (AW < 1 || AW > 12) begin : g_bad_aw
         $error("trace_ring_buf: AW must be 1..12");
      end
      if (DW < 1 || DW > 32) begin : g_bad_dw
         $error("trace_ring_buf: DW must be 1..32");
      end
      if (TCW < 1 || TCW > 32) begin : g_bad_tcw
         $error("trace_ring_buf: TCW must be 1..32");
      end
   endgenerate

   logic           active, accept, start, triggered, flush_pend, ready;
   logic           pipe_vld, wrapped, pop;
   fctl_t          fctl;
   logic [1:0]     mode;
   logic [SW-1:0]  size, rd_left;
   logic [TCW-1:0] tcnt;
   logic [AW-1:0]  wr_ptr, rd_ptr;
   logic [DW-1:0]  rd_word;
   logic [31:0]    fctl_word;

   assign pop = reg_rd && (reg_addr == A_DATA);

   trb_ctl #(.AW(AW), .TCW(TCW)) u_ctl (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .trc_valid, .trig_in, .flush_in,
      .pipe_vld, .active, .accept, .start, .triggered, .flush_pend, .fctl,
      .mode, .size, .tcnt, .ready
   );

   trb_store #(.AW(AW), .DW(DW)) u_store (
      .clk, .rst_n, .accept, .start, .din(trc_data), .size, .rd_addr(rd_ptr),
      .pipe_vld, .wr_ptr, .wrapped, .rd_word
   );

   trb_reader #(.AW(AW)) u_rdr (
      .clk, .rst_n, .start, .ready, .wrapped, .wr_ptr, .size, .pop, .rd_ptr, .rd_left
   );

   always_comb begin
      fctl_word             = '0;
      fctl_word[FC_FL_IN]   = fctl.fl_in;
      fctl_word[FC_FL_TRIG] = fctl.fl_trig;
      fctl_word[FC_FL_MAN]  = flush_pend;
      fctl_word[FC_TRIG_EN] = fctl.trig_en;
      fctl_word[FC_STOP_FL] = fctl.stop_fl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
      end else if (reg_rd) begin
         case (reg_addr)
            A_CTRL:  reg_rdata <= {31'd0, active};
            A_STAT:  reg_rdata <= {29'd0, ready, triggered, 1'b0};
            A_MODE:  reg_rdata <= {30'd0, mode};
            A_SIZE:  reg_rdata <= 32'(size);
            A_TCNT:  reg_rdata <= 32'(tcnt);
            A_FCTL:  reg_rdata <= fctl_word;
            A_DATA:  reg_rdata <= (rd_left != '0) ? 32'(rd_word) : 32'hFFFF_FFFF;
            A_RPTR:  reg_rdata <= 32'(rd_ptr);
            A_WPTR:  reg_rdata <= 32'(wr_ptr);
            default: reg_rdata <= '0;
         endcase
      end
   end
endmodule

// File: rtl/trb_chk.sv
module trb_chk
   import trb_pkg::*;
#(
   parameter int unsigned AW = 4,
   localparam int unsigned SW = AW + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_wdata,
   input logic [31:0]       reg_rdata,
   input logic              trig_in,
   input logic              flush_in,
   input logic              active,
   input logic              triggered,
   input logic              flush_pend,
   input logic              pipe_vld,
   input logic [AW-1:0]     wr_ptr,
   input logic [SW-1:0]     size,
   input logic [SW-1:0]     rd_left
);
   logic go;
   assign go = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];

   AST_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> ({1'b0, wr_ptr} < size)); // R2

   AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !pipe_vld && !go) |=> $stable(wr_ptr)); // R2

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(size)); // R4

   AST_TRIG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (triggered && !go) |=> triggered); // R6

   AST_FLUSH_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_pend && !(reg_wr && reg_addr == A_FCTL && reg_wdata[FC_FL_MAN])
       && !flush_in && !trig_in) |=> !flush_pend); // R7

   AST_DRAINED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == A_DATA && rd_left == '0) |=> (reg_rdata == 32'hFFFF_FFFF)); // R10
endmodule

bind trace_ring_buf trb_chk #(.AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in), .flush_in(flush_in),
   .active(active), .triggered(triggered), .flush_pend(flush_pend), .pipe_vld(pipe_vld),
   .wr_ptr(wr_ptr), .size(size), .rd_left(rd_left)
);

// File: tb/sim_trace_ring_buf.sv
`timescale 1ns/1ps
module sim_trace_ring_buf;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0, tv = 1'b0, ti = 1'b0, fi = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wd = '0, td = '0;
   logic [31:0] rdata;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   trace_ring_buf u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
      .reg_wdata(wd), .reg_rdata(rdata), .trc_valid(tv), .trc_data(td),
      .trig_in(ti), .flush_in(fi)
   );

   // behavioural reference model, advanced on every rising edge
   bit          m_act, m_trg, m_pend, m_pv, m_wrap, m_rdyd;
   int          m_post, m_mode, m_size, m_tcnt, m_wp, m_rp, m_left;
   logic [31:0] m_fc, m_pd, m_exp;
   logic [31:0] m_mem [DEPTH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_trg = 0; m_pend = 0; m_pv = 0; m_wrap = 0; m_rdyd = 1;
         m_post = 0; m_mode = 0; m_size = DEPTH; m_tcnt = 0;
         m_wp = 0; m_rp = 0; m_left = 0; m_fc = 0; m_pd = 0; m_exp = 0;
      end else begin
         bit st, halt, acc, tt, plast, freq, stp, rdy, ld, pop;
         int nsize, nmode, ntcnt;
         st    = wr && addr == 0 && wd[0];
         halt  = wr && addr == 0 && !wd[0];
         acc   = m_act && m_mode == 0 && tv;
         tt    = m_act && m_fc[8] && ti && !m_trg;
         plast = acc && m_trg && m_post == 1;
         freq  = (wr && addr == 5 && wd[6]) || (m_fc[4] && fi) || (m_fc[5] && tt);
         stp   = halt || (tt && m_tcnt == 0) || plast || (m_pend && m_fc[12]);
         rdy   = !m_act && !m_pv && !m_pend;
         pop   = rd && addr == 6;
         if (rd) begin
            case (addr)
               0: m_exp = 32'(m_act);
               1: m_exp = (32'(m_trg) << 1) | (32'(rdy) << 2);
               2: m_exp = 32'(m_mode);
               3: m_exp = 32'(m_size);
               4: m_exp = 32'(m_tcnt);
               5: m_exp = m_fc | (32'(m_pend) << 6);
               6: m_exp = (m_left > 0) ? m_mem[m_rp] : 32'hFFFF_FFFF;
               7: m_exp = 32'(m_rp);
               8: m_exp = 32'(m_wp);
               default: m_exp = 0;
            endcase
         end
         // reader (old pointer state)
         ld = rdy && !m_rdyd;
         if (st) begin m_rp = 0; m_left = 0; end
         else if (ld) begin
            m_rp = m_wrap ? m_wp : 0;
            m_left = m_wrap ? m_size : m_wp;
         end else if (pop && m_left > 0) begin
            m_rp = (m_rp == m_size - 1) ? 0 : m_rp + 1;
            m_left--;
         end
         m_rdyd = rdy;
         // storage
         if (m_pv) m_mem[m_wp] = m_pd;
         if (st) begin m_wp = 0; m_wrap = 0; end
         else if (m_pv) begin
            if (m_wp == m_size - 1) begin m_wp = 0; m_wrap = 1; end
            else m_wp++;
         end
         m_pv = acc && !st;
         m_pd = td;
         // control
         nsize = m_size; nmode = m_mode; ntcnt = m_tcnt;
         if (wr && !m_act) begin
            if (addr == 2) nmode = int'(wd & 3);
            if (addr == 3 && wd >= 1 && wd <= DEPTH) nsize = int'(wd);
            if (addr == 4) ntcnt = int'(wd & 32'hFFFF);
         end
         if (tt) m_post = m_tcnt;
         else if (acc && m_trg && m_post != 0) m_post--;
         if (st) m_trg = 0; else if (tt) m_trg = 1;
         if (st) m_act = 1; else if (stp) m_act = 0;
         m_pend = freq;
         if (wr && addr == 5) m_fc = wd & 32'h0000_1130;
         m_size = nsize; m_mode = nmode; m_tcnt = ntcnt;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [3:0] a, input logic [31:0] d);
      wr = 1; addr = a; wd = d;
      @(negedge clk);
      wr = 0;
   endtask

   // read with per-clock model comparison; value returned for direct checks
   task automatic rreg(input logic [3:0] a, input string tag, output logic [31:0] v);
      rd = 1; addr = a;
      @(negedge clk);
      rd = 0;
      v = rdata;
      chk({tag, " model"}, rdata, m_exp);
   endtask

   task automatic rexp(input logic [3:0] a, input string tag, input logic [31:0] e);
      logic [31:0] v;
      rreg(a, tag, v);
      chk(tag, v, e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic push_run(input int n, input logic [31:0] base,
                           input int trig_at, input int trig2_at, input int fl_at);
      for (int i = 0; i < n; i++) begin
         tv = 1; td = base + 32'(i);
         ti = (i == trig_at) || (i == trig2_at);
         fi = (i == fl_at);
         @(negedge clk);
      end
      tv = 0; ti = 0; fi = 0;
   endtask

   initial begin
      #800000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rexp(1, "R1 status", 32'h4);
      rexp(0, "R1 ctrl", 32'h0);
      rexp(3, "R1 size", 32'd16);
      rexp(8, "R1 wrptr", 32'h0);
      rexp(6, "R1 data", 32'hFFFF_FFFF);
      rexp(2, "R1 mode", 32'h0);

      // R4 size limits while idle
      wreg(3, 0);  rexp(3, "R4 size zero ignored", 32'd16);
      wreg(3, 17); rexp(3, "R4 size too big ignored", 32'd16);
      wreg(3, 8);  rexp(3, "R4 size accepted idle", 32'd8);

      // R10/R11 no wrap
      wreg(0, 1);
      push_run(5, 32'h100, -1, -1, -1);
      wreg(0, 0);
      idle(3);
      rexp(1, "R9 ready after stop", 32'h4);
      rexp(8, "R11 wrptr 5", 32'd5);
      for (int i = 0; i < 5; i++) rexp(6, "R10 word in order", 32'h100 + 32'(i));
      rexp(6, "R10 drained ones", 32'hFFFF_FFFF);
      rexp(7, "R11 rdptr", 32'd5);

      // R2 wrap
      wreg(0, 1);
      push_run(11, 32'h200, -1, -1, -1);
      wreg(0, 0);
      idle(3);
      rexp(8, "R2 wrptr wrapped", 32'd3);
      for (int i = 0; i < 8; i++) rexp(6, "R10 wrapped oldest first", 32'h203 + 32'(i));
      rexp(6, "R10 wrapped drained", 32'hFFFF_FFFF);
      idle(2);
      rexp(8, "R2 pointer holds idle", 32'd3);

      // R4 frozen config while running
      wreg(4, 3);
      wreg(0, 1);
      wreg(3, 4); wreg(2, 1); wreg(4, 9);
      rexp(3, "R4 size frozen", 32'd8);
      rexp(2, "R4 mode frozen", 32'd0);
      rexp(4, "R4 tcount frozen", 32'd3);
      wreg(0, 0);
      idle(3);

      // R5/R6 trigger with count 3, second trigger ignored
      wreg(5, 32'h100);
      wreg(0, 1);
      push_run(10, 32'h300, 2, 3, -1);
      idle(3);
      rexp(0, "R5 stopped after count", 32'd0);
      rexp(1, "R5 triggered and ready", 32'h6);
      rexp(8, "R6 six words stored", 32'd6);
      for (int i = 0; i < 6; i++) rexp(6, "R5 trigger data", 32'h300 + 32'(i));

      // R5 count zero
      wreg(4, 0);
      wreg(0, 1);
      push_run(6, 32'h400, 2, -1, -1);
      idle(3);
      rexp(8, "R5 count zero stops at trigger", 32'd3);

      // R7/R8 trigger-caused flush with stop
      wreg(4, 10);
      wreg(5, 32'h1120);
      wreg(0, 1);
      push_run(8, 32'h500, 2, -1, -1);
      idle(3);
      rexp(8, "R8 trigger flush stop words", 32'd4);
      rexp(0, "R8 stopped by flush", 32'd0);

      // R7/R8 input flush with stop
      wreg(5, 32'h1010);
      wreg(0, 1);
      push_run(6, 32'h600, -1, -1, 1);
      idle(3);
      rexp(8, "R7 flush input stop words", 32'd3);

      // R8 flush without stop keeps capture
      wreg(5, 32'h0010);
      wreg(0, 1);
      push_run(4, 32'h700, -1, -1, 1);
      idle(2);
      rexp(0, "R8 no stop keeps capture", 32'd1);
      wreg(0, 0);
      idle(3);

      // R7/R9 manual flush
      wreg(5, 32'h40);
      rexp(5, "R7 manual flush pending", 32'h40);
      rexp(5, "R7 manual flush self clear", 32'h0);
      wreg(5, 32'h40);
      rexp(1, "R9 not ready while flushing", 32'h0);
      rexp(1, "R9 ready after flush", 32'h4);

      // R3 non-circular mode stores nothing
      wreg(2, 1);
      rexp(2, "R3 mode readback", 32'd1);
      wreg(0, 1);
      push_run(3, 32'h800, -1, -1, -1);
      wreg(0, 0);
      idle(3);
      rexp(8, "R3 nothing stored", 32'd0);
      rexp(6, "R3 data empty", 32'hFFFF_FFFF);
      wreg(2, 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule